// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the two timing strobes of a multiplexed external memory bus. The first is an address-latch pulse that tells external logic to capture the low address byte. The second is an active-low code-read strobe. The block runs directly on the oscillator clock and splits time into machine cycles of twelve clocks. At the start of each machine cycle it samples what kind of bus cycle the core is about to run: an internal fetch, an external code fetch, an external data transfer, or a code-table read. It also samples whether the core executes from external program memory, and the state of a software bit that suppresses the address-latch pulse.

Each machine cycle holds two address-latch slots and two code-read slots, and the two kinds never overlap. A data transfer drops the second latch pulse and both code-read activations of its machine cycle. When the suppress bit is set and the core runs internal code, the latch pulse appears only in data-transfer and table-read cycles. In all other cycles a flag shows that the pin should rest weakly high. While the core executes externally, the suppress bit has no effect.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rstN` is low, `ale`=0, `psenN`=1 and `aleWeakHigh`=0. Machine cycle 0 starts at the first rising clock edge with `rstN` high, and uses the inputs present at that edge.
- R2: A machine cycle is 12 clocks, numbered phase 0 to 11 from the edge that starts it. In an enabled cycle `ale` is high in phases 0, 1, 6 and 7 and low in all other phases, so one pulse comes every 6 clocks.
- R3: In a data-transfer cycle (`cycleKind`=2'b10), the pulse in phases 6–7 is omitted and the pulse in phases 0–1 is kept.
- R4: `psenN` is low in phases 3–5 and 9–11 of every cycle that is an external code fetch (`cycleKind`=2'b01). The same holds for any cycle other than a data transfer while `extExec`=1. Otherwise `psenN` is high.
- R5: `psenN` stays high for the whole of a data-transfer cycle, even with `extExec`=1.
- R6: With `aleDisable`=1 and `extExec`=0, `ale` stays low for the whole cycle and `aleWeakHigh`=1, unless the cycle is a data transfer or a table read (`cycleKind`=2'b11). Those two kinds pulse as in R2/R3 with `aleWeakHigh`=0. Internal fetch is `cycleKind`=2'b00.
- R7: With `extExec`=1, `aleDisable` has no effect: `ale` follows R2/R3 and `aleWeakHigh`=0.
- R8: `psenN` is never low while `ale` is high.
- R9: The inputs are sampled only at the edge that starts a machine cycle. A change during phases 0–10 has no effect until the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleKind | input | 2 | Bus cycle type for the next machine cycle |
| extExec | input | 1 | Core executes from external program memory |
| aleDisable | input | 1 | Software bit confining the latch pulse to data/table cycles |
| ale | output | 1 | Address-latch strobe, active high |
| psenN | output | 1 | Code-read strobe, active low |
| aleWeakHigh | output | 1 | Latch pin rests weakly high this cycle |

## Verification
The hardest case to reach from the ports is an input change in the middle of a machine cycle. The outputs must show the old cycle type until the boundary, then switch exactly at phase 0. The stimulus rewrites all three inputs at phase 5 of a cycle and compares the rest of that cycle against the old pattern. A reset forced during a low code-read window checks that the strobes drop to their idle levels at once. A back-to-back sequence of data transfers, table reads and suppressed cycles covers every combination of suppress bit and execution mode.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

  typedef enum logic [1:0] {
    CYC_INTERNAL   = 2'b00,
    CYC_EXT_CODE   = 2'b01,
    CYC_DATA_XFER  = 2'b10,
    CYC_TABLE_READ = 2'b11
  } cycleKind_e;

  // strobes handed from control to the output stage
  typedef struct packed {
    logic aleOn;
    logic psenOn;
    logic aleWeak;
  } strobeSet_t;

  // what the current machine cycle is doing, frozen for 12 clocks
  typedef struct packed {
    cycleKind_e kind;
    logic       extExec;
    logic       aleGate;
  } cycleCtx_t;

endpackage

// File: rtl/bus_strobe_ctrl.sv
module bus_strobe_ctrl
  import strobe_pkg::*;
#(
  parameter int PHASES     = 12,
  parameter int ALE_WIDTH  = 2,
  parameter int PSEN_START = 3,
  localparam int PW        = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  cycleKind_e    kindIn,
  input  logic          extIn,
  input  logic          gateIn,
  output strobeSet_t    nextStrobe,
  output cycleCtx_t     ctxNow,
  output logic [PW-1:0] phaseNow
);

  localparam int HALF = PHASES / 2;
  localparam logic [PW-1:0] LAST_P = PW'(PHASES - 1);
  localparam logic [PW-1:0] HALF_P = PW'(HALF);
  localparam logic [PW-1:0] ALEW_P = PW'(ALE_WIDTH);
  localparam logic [PW-1:0] PSEN_P = PW'(PSEN_START);

  logic [PW-1:0] phase, phaseNext, offset;
  cycleCtx_t     ctx, ctxNext;
  logic          wrap, secondHalf, isXfer, isTable;
  logic          aleAllowed, aleDrop, psenWanted;

  // decode is done on the upcoming phase so the output stage can register it
  always_comb begin
    wrap       = (phase == LAST_P);
    phaseNext  = wrap ? '0 : phase + 1'b1;
    ctxNext    = wrap ? '{kind: kindIn, extExec: extIn, aleGate: gateIn} : ctx;
    secondHalf = (phaseNext >= HALF_P);
    offset     = secondHalf ? phaseNext - HALF_P : phaseNext;
    isXfer     = (ctxNext.kind == CYC_DATA_XFER);
    isTable    = (ctxNext.kind == CYC_TABLE_READ);
    aleAllowed = !ctxNext.aleGate || ctxNext.extExec || isXfer || isTable;
    aleDrop    = isXfer && secondHalf;
    psenWanted = !isXfer && (ctxNext.kind == CYC_EXT_CODE || ctxNext.extExec);
    nextStrobe.aleOn   = (offset < ALEW_P) && aleAllowed && !aleDrop;
    nextStrobe.psenOn  = (offset >= PSEN_P) && psenWanted;
    nextStrobe.aleWeak = !aleAllowed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= LAST_P;
      ctx   <= '{kind: CYC_INTERNAL, extExec: 1'b0, aleGate: 1'b0};
    end else begin
      phase <= phaseNext;
      ctx   <= ctxNext;
    end
  end

  assign ctxNow   = ctx;
  assign phaseNow = phase;

  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == LAST_P) |=> (phase == '0));

  assert_ctx_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (phase != LAST_P) |=> $stable(ctx));

endmodule

// File: rtl/bus_strobe_out.sv
module bus_strobe_out
  import strobe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobeSet_t nextStrobe,
  output logic       ale,
  output logic       psenN,
  output logic       aleWeak
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ale     <= 1'b0;
      psenN   <= 1'b1;
      aleWeak <= 1'b0;
    end else begin
      ale     <= nextStrobe.aleOn;
      psenN   <= !nextStrobe.psenOn;
      aleWeak <= nextStrobe.aleWeak;
    end
  end

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> psenN);

  assert_weak_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    aleWeak |-> !ale);

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ale) |=> ale);

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import strobe_pkg::*;
#(
  parameter int PHASES     = 12,
  parameter int ALE_WIDTH  = 2,
  parameter int PSEN_START = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cycleKind,
  input  logic       extExec,
  input  logic       aleDisable,
  output logic       ale,
  output logic       psenN,
  output logic       aleWeakHigh
);

  localparam int PW = $clog2(PHASES);
  localparam logic [PW-1:0] HALF_P = PW'(PHASES / 2);

  strobeSet_t    nextStrobe;
  cycleCtx_t     ctxNow;
  logic [PW-1:0] phaseNow;

  bus_strobe_ctrl #(
    .PHASES(PHASES), .ALE_WIDTH(ALE_WIDTH), .PSEN_START(PSEN_START)
  ) ctrl (
    .clk(clk), .rstN(rstN),
    .kindIn(cycleKind_e'(cycleKind)), .extIn(extExec), .gateIn(aleDisable),
    .nextStrobe(nextStrobe), .ctxNow(ctxNow), .phaseNow(phaseNow)
  );

  bus_strobe_out outStage (
    .clk(clk), .rstN(rstN), .nextStrobe(nextStrobe),
    .ale(ale), .psenN(psenN), .aleWeak(aleWeakHigh)
  );

  assert_xfer_no_psen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctxNow.kind == CYC_DATA_XFER) |-> psenN);

  assert_xfer_skip_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctxNow.kind == CYC_DATA_XFER && phaseNow == HALF_P) |-> !ale);

  assert_ext_ignores_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctxNow.extExec && phaseNow == '0) |-> (ale && !aleWeakHigh));

endmodule

// File: tb/tb_bus_strobe_gen.sv
`timescale 1ns/1ps
module tb_bus_strobe_gen;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cycleKind = 2'b00;
  logic extExec = 1'b0;
  logic aleDisable = 1'b0;
  logic ale, psenN, aleWeakHigh;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_strobe_gen dut (
    .clk(clk), .rstN(rstN), .cycleKind(cycleKind), .extExec(extExec),
    .aleDisable(aleDisable), .ale(ale), .psenN(psenN), .aleWeakHigh(aleWeakHigh)
  );

  // entry: kind[28:27] ext[26] dis[25] aleMask[24:13] psenLowMask[12:1] weak[0]
  localparam int NV = 14;
  localparam logic [28:0] VEC [NV] = '{
    {2'b01, 1'b0, 1'b0, 12'h0C3, 12'hE38, 1'b0},
    {2'b00, 1'b0, 1'b0, 12'h0C3, 12'h000, 1'b0},
    {2'b10, 1'b0, 1'b0, 12'h003, 12'h000, 1'b0},
    {2'b10, 1'b0, 1'b0, 12'h003, 12'h000, 1'b0},
    {2'b11, 1'b0, 1'b0, 12'h0C3, 12'h000, 1'b0},
    {2'b00, 1'b1, 1'b0, 12'h0C3, 12'hE38, 1'b0},
    {2'b10, 1'b1, 1'b0, 12'h003, 12'h000, 1'b0},
    {2'b00, 1'b0, 1'b1, 12'h000, 12'h000, 1'b1},
    {2'b01, 1'b0, 1'b1, 12'h000, 12'hE38, 1'b1},
    {2'b10, 1'b0, 1'b1, 12'h003, 12'h000, 1'b0},
    {2'b11, 1'b0, 1'b1, 12'h0C3, 12'h000, 1'b0},
    {2'b00, 1'b1, 1'b1, 12'h0C3, 12'hE38, 1'b0},
    {2'b10, 1'b1, 1'b1, 12'h003, 12'h000, 1'b0},
    {2'b11, 1'b1, 1'b1, 12'h0C3, 12'hE38, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // runs one machine cycle from a negedge; optional input change after phase 5
  task automatic runCycle(input logic [28:0] v, input bit midChange,
                          input logic [1:0] newKind, input bit newExt, input bit newDis);
    cycleKind  = v[28:27];
    extExec    = v[26];
    aleDisable = v[25];
    for (int p = 0; p < 12; p++) begin
      @(posedge clk);
      @(negedge clk);
      check(ale == v[13+p], "R2 R3 R6 R7 R9 ale", int'(ale), int'(v[13+p]));
      check(psenN == !v[1+p], "R4 R5 R9 psenN", int'(psenN), int'(!v[1+p]));
      check(aleWeakHigh == v[0], "R6 R7 aleWeakHigh", int'(aleWeakHigh), int'(v[0]));
      check(!(ale && !psenN), "R8 overlap", int'(ale && !psenN), 0);
      if (midChange && p == 5) begin
        cycleKind  = newKind;
        extExec    = newExt;
        aleDisable = newDis;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset levels
    check(ale == 1'b0, "R1 reset ale", int'(ale), 0);
    check(psenN == 1'b1, "R1 reset psenN", int'(psenN), 1);
    check(aleWeakHigh == 1'b0, "R1 reset weak", int'(aleWeakHigh), 0);
    rstN = 1'b1;
    // R1 first cycle uses inputs at first edge (entry 0 is an external fetch)
    for (int i = 0; i < NV; i++) runCycle(VEC[i], 1'b0, 2'b00, 1'b0, 1'b0);

    // R9: inputs switched mid-cycle to a suppressed internal fetch; old pattern holds
    runCycle(VEC[0], 1'b1, 2'b00, 1'b0, 1'b1);
    runCycle({2'b00, 1'b0, 1'b1, 12'h000, 12'h000, 1'b1}, 1'b1, 2'b10, 1'b1, 1'b0);
    runCycle({2'b10, 1'b1, 1'b0, 12'h003, 12'h000, 1'b0}, 1'b0, 2'b00, 1'b0, 1'b0);

    // R1: asynchronous reset in the middle of a low code-read window
    cycleKind = 2'b01; extExec = 1'b0; aleDisable = 1'b0;
    repeat (4) @(negedge clk);
    check(psenN == 1'b0, "R4 before reset psenN", int'(psenN), 0);
    rstN = 1'b0;
    #1;
    check(psenN == 1'b1, "R1 async reset psenN", int'(psenN), 1);
    check(ale == 1'b0, "R1 async reset ale", int'(ale), 0);
    @(negedge clk);
    rstN = 1'b1;
    runCycle({2'b11, 1'b0, 1'b1, 12'h0C3, 12'h000, 1'b0}, 1'b0, 2'b00, 1'b0, 1'b0);
    runCycle(VEC[0], 1'b0, 2'b00, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule